// File: doc/BRIEF.md
# Toggle-Bit Completion Poller

This block sits on the host side of a parallel flash memory and waits for a program or erase operation that is already running to finish. It does not send the command that starts the operation. When `start_i` is pulsed, it captures a status address. It then reads that address in pairs and compares the busy-toggle bit (bit 6) of each read with the read before it. If the bit holds steady, the memory has finished.

If the toggle bit keeps changing, the poller examines the time-limit bit (bit 5) of the most recent read. A set time-limit bit is not taken as a failure right away. The toggle bit can stop at the same moment the limit flag rises, so the poller takes one more confirming pair of reads first. Only if the toggle bit still changes across that pair does it declare a failure. In that case it writes the reset command byte 0xF0 to put the memory back into array-read mode.

A pair counter bounds how long the poller will wait on a memory that toggles forever without raising bit 5. When the count runs out, it aborts with a separate watchdog flag. Completion is reported as a one-cycle `done_o` pulse, together with `pass_o` and `wdog_o`.

Top module: `tbp_poll_ctrl`

## Requirements
- R1: After `start_i` is sampled high in the idle state, the block issues read transfers (`mem_we_o`=0) at the address presented on `addr_i` in that cycle. A transfer holds `mem_req_o` and `mem_addr_o` steady until a cycle with `mem_ack_i` high, and each acknowledged cycle completes exactly one transfer.
- R2: If a pair of reads returns the same value of bit 6, the block finishes with `pass_o`=1 and makes no write. All other status bits are ignored for this decision.
- R3: If bit 6 differs across a pair and bit 5 of the second read is 1, the block takes two more reads. If bit 6 is equal across these two, the block finishes with `pass_o`=1 and makes no write.
- R4: If bit 6 differs across a pair and bit 5 of the second read is 0, the block starts a new pair of reads.
- R5: If bit 6 still differs across the confirming pair of R3, the block writes 0xF0 (`mem_we_o`=1) to the captured address. It then finishes with `pass_o`=0 and `wdog_o`=0.
- R6: After `MAX_POLLS` pairs that each toggled with bit 5 clear, the block writes 0xF0 and finishes with `pass_o`=0 and `wdog_o`=1. In every other outcome `wdog_o` is 0.
- R7: `start_i` has no effect while `busy_o` is high. The address in use and the sequence of transfers do not change.
- R8: `done_o` is high for exactly one cycle, in the cycle after the final transfer is acknowledged. In that same cycle `busy_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin polling (ignored while busy) |
| addr_i | input | ADDR_W | Status address, captured at start |
| busy_o | output | 1 | Poll in progress |
| done_o | output | 1 | One-cycle completion pulse |
| pass_o | output | 1 | Operation completed successfully (valid with done_o) |
| wdog_o | output | 1 | Aborted by poll budget (valid with done_o) |
| mem_req_o | output | 1 | Transfer request to memory |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | ADDR_W | Transfer address |
| mem_wdata_o | output | DATA_W | Write data (reset command) |
| mem_ack_i | input | 1 | Transfer complete; read data valid |
| mem_rdata_i | input | DATA_W | Read data |

## Verification
The hardest case to reach is the confirmation branch. A pair must toggle with bit 5 set, and the outcome then depends on whether bit 6 changes across the next two reads. The bench memory model plays out a scripted sequence of status bytes, one per acknowledged read. Its scripts set bit 5 on the second read of a toggling pair and then either hold or flip bit 6. The watchdog path is reached with a reduced `MAX_POLLS` and an alternating script. The stray-start check pulses `start_i` with a different address in the middle of a long poll.

// File: rtl/tbp_pkg.sv
package tbp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_A,
    ST_RD_B,
    ST_CHK_A,
    ST_CHK_B,
    ST_ABORT
  } tbp_state_e;
endpackage

// File: rtl/tbp_toggle_judge.sv
module tbp_toggle_judge #(
  parameter int DATA_W     = 8,
  parameter int TOGGLE_BIT = 6,
  parameter int LIMIT_BIT  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              capture_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              toggled_o,
  output logic              limit_o
);
  logic ref_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ref_q <= 1'b0;
    else if (capture_i) ref_q <= rdata_i[TOGGLE_BIT];
  end

  assign toggled_o = rdata_i[TOGGLE_BIT] ^ ref_q;
  assign limit_o   = rdata_i[LIMIT_BIT];
endmodule

// File: rtl/tbp_poll_budget.sv
module tbp_poll_budget #(
  parameter int MAX_POLLS = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic bump_i,
  output logic last_o
);
  localparam int CNT_W = $clog2(MAX_POLLS + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (bump_i)  cnt_q <= cnt_q + 1'b1;
  end

  // the pair now being judged is the final one allowed
  assign last_o = (cnt_q == CNT_W'(MAX_POLLS - 1));

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CNT_W'(MAX_POLLS)); // R6
endmodule

// File: rtl/tbp_result_reg.sv
module tbp_result_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fin_i,
  input  logic fin_pass_i,
  input  logic fin_wdog_i,
  output logic done_o,
  output logic pass_o,
  output logic wdog_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o <= 1'b0;
      pass_o <= 1'b0;
      wdog_o <= 1'b0;
    end else begin
      done_o <= fin_i;
      if (fin_i) begin
        pass_o <= fin_pass_i;
        wdog_o <= fin_wdog_i;
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R8
  AST_WDOG_NOT_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && wdog_o) |-> !pass_o); // R6
endmodule

// File: rtl/tbp_poll_ctrl.sv
module tbp_poll_ctrl
  import tbp_pkg::*;
#(
  parameter int          ADDR_W     = 16,
  parameter int          DATA_W     = 8,
  parameter int          MAX_POLLS  = 1024,
  parameter int          TOGGLE_BIT = 6,
  parameter int          LIMIT_BIT  = 5,
  parameter logic [7:0]  RESET_CMD  = 8'hF0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              pass_o,
  output logic              wdog_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  tbp_state_e        state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic              abort_wdog_q, abort_wdog_d;
  logic              capture, clear, bump;
  logic              fin, fin_pass, fin_wdog;
  logic              toggled, limit, last;

  tbp_toggle_judge #(
    .DATA_W    (DATA_W),
    .TOGGLE_BIT(TOGGLE_BIT),
    .LIMIT_BIT (LIMIT_BIT)
  ) u_judge (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .capture_i(capture),
    .rdata_i  (mem_rdata_i),
    .toggled_o(toggled),
    .limit_o  (limit)
  );

  tbp_poll_budget #(
    .MAX_POLLS(MAX_POLLS)
  ) u_budget (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(clear),
    .bump_i (bump),
    .last_o (last)
  );

  tbp_result_reg u_result (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .fin_i     (fin),
    .fin_pass_i(fin_pass),
    .fin_wdog_i(fin_wdog),
    .done_o    (done_o),
    .pass_o    (pass_o),
    .wdog_o    (wdog_o)
  );

  always_comb begin
    state_d      = state_q;
    abort_wdog_d = abort_wdog_q;
    capture      = 1'b0;
    clear        = 1'b0;
    bump         = 1'b0;
    fin          = 1'b0;
    fin_pass     = 1'b0;
    fin_wdog     = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          clear   = 1'b1;
          state_d = ST_RD_A;
        end
      end
      ST_RD_A: begin
        if (mem_ack_i) begin
          capture = 1'b1;
          state_d = ST_RD_B;
        end
      end
      ST_RD_B: begin
        if (mem_ack_i) begin
          if (!toggled) begin
            fin      = 1'b1;
            fin_pass = 1'b1;
            state_d  = ST_IDLE;
          end else if (limit) begin
            state_d = ST_CHK_A;
          end else if (last) begin
            abort_wdog_d = 1'b1;
            state_d      = ST_ABORT;
          end else begin
            bump    = 1'b1;
            state_d = ST_RD_A;
          end
        end
      end
      ST_CHK_A: begin
        if (mem_ack_i) begin
          capture = 1'b1;
          state_d = ST_CHK_B;
        end
      end
      ST_CHK_B: begin
        if (mem_ack_i) begin
          if (!toggled) begin
            fin      = 1'b1;
            fin_pass = 1'b1;
            state_d  = ST_IDLE;
          end else begin
            abort_wdog_d = 1'b0;
            state_d      = ST_ABORT;
          end
        end
      end
      ST_ABORT: begin
        if (mem_ack_i) begin
          fin      = 1'b1;
          fin_wdog = abort_wdog_q;
          state_d  = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      addr_q       <= '0;
      abort_wdog_q <= 1'b0;
    end else begin
      state_q      <= state_d;
      abort_wdog_q <= abort_wdog_d;
      if (state_q == ST_IDLE && start_i) addr_q <= addr_i;
    end
  end

  assign busy_o      = (state_q != ST_IDLE);
  assign mem_req_o   = busy_o;
  assign mem_we_o    = (state_q == ST_ABORT);
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = mem_we_o ? DATA_W'(RESET_CMD) : '0;

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> mem_req_o); // R1
  AST_ADDR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> $stable(mem_addr_o)); // R1
  AST_WE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> $stable(mem_we_o)); // R1
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o); // R8
  AST_BUSY_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(mem_addr_o)); // R7
endmodule

// File: tb/tb_tbp_poll_ctrl.sv
module tb_tbp_poll_ctrl;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;
  localparam int MAXP   = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic              busy, done, pass, wdog;
  logic              req, we;
  logic [ADDR_W-1:0] maddr;
  logic [DATA_W-1:0] wdata;
  logic              ack = 1'b0;
  logic [DATA_W-1:0] rdata = '0;

  int n_chk = 0, n_bad = 0;
  int n_rd, n_wr, n_bad_addr, idx;
  logic [ADDR_W-1:0] exp_addr;
  logic [DATA_W-1:0] last_wd;
  logic [DATA_W-1:0] script [0:63];

  always #2 clk = ~clk;

  tbp_poll_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MAX_POLLS(MAXP)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .addr_i(addr),
    .busy_o(busy), .done_o(done), .pass_o(pass), .wdog_o(wdog),
    .mem_req_o(req), .mem_we_o(we), .mem_addr_o(maddr), .mem_wdata_o(wdata),
    .mem_ack_i(ack), .mem_rdata_i(rdata)
  );

  // memory model: acknowledge each request on the following half cycle
  always @(negedge clk) begin
    if (ack) ack <= 1'b0;
    else if (req) begin
      ack <= 1'b1;
      if (maddr != exp_addr) n_bad_addr = n_bad_addr + 1;
      if (we) begin
        n_wr    = n_wr + 1;
        last_wd = wdata;
      end else begin
        rdata <= script[idx];
        idx   = (idx < 63) ? idx + 1 : idx;
        n_rd  = n_rd + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_script();
    for (int i = 0; i < 64; i++) script[i] = 8'h00;
    idx = 0; n_rd = 0; n_wr = 0; n_bad_addr = 0; last_wd = '0;
  endtask

  task automatic kick(input logic [ADDR_W-1:0] a);
    @(negedge clk);
    exp_addr = a; addr = a; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // waits for done, checks the single-cycle pulse and idle busy
  task automatic wait_done(input string tag);
    int cyc = 0;
    while (!done && cyc < 2000) begin
      @(negedge clk);
      cyc++;
    end
    chk(done, {tag, " done seen"}, done, 1);
    chk(!busy, "R8 busy low with done", busy, 0);
    @(negedge clk);
    chk(!done, "R8 done one cycle", done, 0);
  endtask

  task automatic t_reset();
    chk(!busy && !done && !req, "R8 reset idle", {busy, done, req}, 0);
  endtask

  task automatic t_steady();
    clear_script();
    script[0] = 8'h01; script[1] = 8'h8F; // bit6 equal, others differ
    kick(16'h1234);
    wait_done("R2");
    chk(pass == 1'b1 && wdog == 1'b0, "R2 pass", {pass, wdog}, 2);
    chk(n_rd == 2 && n_wr == 0, "R2 transfer count", n_rd * 16 + n_wr, 32);
    chk(n_bad_addr == 0, "R1 read address", n_bad_addr, 0);
  endtask

  task automatic t_repoll_and_stray_start();
    clear_script();
    script[0] = 8'h00; script[1] = 8'h40;
    script[2] = 8'h40; script[3] = 8'h00;
    script[4] = 8'h00; script[5] = 8'h00;
    kick(16'h0AAA);
    repeat (3) @(negedge clk);
    addr = 16'hBEEF; start = 1'b1; // R7 stray start while busy
    @(negedge clk);
    start = 1'b0;
    wait_done("R4");
    chk(pass == 1'b1, "R4 pass after repoll", pass, 1);
    chk(n_rd == 6 && n_wr == 0, "R4 read count", n_rd, 6);
    chk(n_bad_addr == 0, "R7 address unchanged", n_bad_addr, 0);
    repeat (4) @(negedge clk);
    chk(!busy && n_rd == 6, "R7 no extra poll", n_rd, 6);
  endtask

  task automatic t_confirm_pass();
    clear_script();
    script[0] = 8'h00; script[1] = 8'h60;
    script[2] = 8'h20; script[3] = 8'h20;
    kick(16'h0555);
    wait_done("R3");
    chk(pass == 1'b1 && wdog == 1'b0, "R3 pass on confirm", {pass, wdog}, 2);
    chk(n_rd == 4 && n_wr == 0, "R3 reads no write", n_rd * 16 + n_wr, 64);
  endtask

  task automatic t_confirm_fail();
    clear_script();
    script[0] = 8'h00; script[1] = 8'h60;
    script[2] = 8'h20; script[3] = 8'h60;
    kick(16'h02AA);
    wait_done("R5");
    chk(pass == 1'b0 && wdog == 1'b0, "R5 fail flags", {pass, wdog}, 0);
    chk(n_rd == 4 && n_wr == 1, "R5 one reset write", n_rd * 16 + n_wr, 65);
    chk(last_wd == 8'hF0, "R5 reset byte", last_wd, 8'hF0);
    chk(n_bad_addr == 0, "R5 write address", n_bad_addr, 0);
  endtask

  task automatic t_watchdog();
    clear_script();
    for (int i = 0; i < 64; i++) script[i] = (i % 2) ? 8'h40 : 8'h00;
    kick(16'h7000);
    wait_done("R6");
    chk(pass == 1'b0 && wdog == 1'b1, "R6 watchdog flags", {pass, wdog}, 1);
    chk(n_rd == 2 * MAXP, "R6 read budget", n_rd, 2 * MAXP);
    chk(n_wr == 1 && last_wd == 8'hF0, "R6 reset write", n_wr, 1);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    exp_addr = '0;
    clear_script();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_steady();
    t_repoll_and_stray_start();
    t_confirm_pass();
    t_confirm_fail();
    t_watchdog();
    t_steady();
    finish_run();
  end

  initial begin
    #(200000 * 4);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end
endmodule